// File: doc/BRIEF.md
# Dual-Parallel Quad-SPI Flash Datapath

This block connects a simple host transaction port to a pair of identical quad-SPI flash devices. Each device has its own 4-bit data bus. Both devices share one serial clock and one select strobe. It runs in one of two modes.

In paired mode, each transfer goes to both devices at once. The opcode and the halved byte address are driven identically on both buses. In the data phase every host byte is split bitwise: even bits go to the lower device and odd bits to the upper device. A whole byte therefore moves per serial clock, and the pair looks to the host like one flash of double width. Read nibbles are put back together into bytes with the same bit mapping.

In single mode only the lower device is used, with a conventional two-nibble-per-byte data phase. The block also reports the bank number and the page and sector sizes that the host must use in the current mode.

Top module: `dpq_flash_ctrl`

## Requirements
- R1: Paired mode is selected only when configuration bits 29 and 30 are both 1. Any other setting gives single mode: only the lower bus is used, the upper select stays high and the upper output enable stays low.
- R2: In paired mode both selects fall and rise in the same cycle. The serial clock is high only while a select is low, and it is low out of reset.
- R3: A transfer first sends the 8-bit opcode as 2 nibbles, then the 24-bit device address as 6 nibbles, most significant nibble first. Bit 3 of each nibble is on IO3. In paired mode both buses carry identical nibbles during these phases.
- R4: The device address is bits 24..1 of the host address in paired mode, and bits 23..0 in single mode.
- R5: A paired write moves one byte per serial clock. The lower nibble is {b6,b4,b2,b0} and the upper nibble is {b7,b5,b3,b1}, with b0 on IO0. wr_ack_o pulses once per byte consumed.
- R6: A single-mode byte takes two serial clocks on the lower bus, high nibble first.
- R7: A read inserts dummy_i clocks with both output enables low. After that, every data clock in paired mode yields one byte, rebuilt as bit 2i = lower IOi and bit 2i+1 = upper IOi. In single mode every second clock yields one byte, high nibble first. Each byte is marked by one rd_valid_o pulse.
- R8: In paired mode, a start with an odd address or an odd length raises err_o for one cycle. No select falls and no transfer takes place. Odd values are legal in single mode.
- R9: bank_o is the host address divided by 32 MiB in paired mode and by 16 MiB in single mode.
- R10: page_o and sect_o are twice the device page (256) and sector (4096) in paired mode, and equal to them in single mode.
- R11: Out of reset the selects are high, the serial clock is low, the output enables are low and busy_o is low.
- R12: A write has no dummy phase. Its serial clock count is 8 plus the data clocks. A zero length ends the transfer right after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 32 | Configuration word; bits 29 and 30 select paired mode |
| start_i | input | 1 | One-cycle request to begin a transfer |
| wr_i | input | 1 | 1 = write data phase, 0 = read |
| op_i | input | 8 | Command opcode |
| addr_i | input | AW | Host byte address |
| len_i | input | LW | Data length in bytes |
| dummy_i | input | DW | Dummy clocks before read data |
| wr_data_i | input | 8 | Current write byte, held until acknowledged |
| wr_ack_o | output | 1 | Write byte consumed |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | rd_data_o holds a new byte |
| busy_o | output | 1 | Transfer in progress |
| err_o | output | 1 | Rejected paired-mode request |
| bank_o | output | AW-24 | Bank number for the host address |
| page_o | output | 32 | Logical page size in bytes |
| sect_o | output | 32 | Logical sector size in bytes |
| sclk_o | output | 1 | Shared serial clock |
| lo_cs_n_o | output | 1 | Lower device select, active low |
| hi_cs_n_o | output | 1 | Upper device select, active low |
| lo_io_o | output | 4 | Lower bus output nibble |
| lo_oe_o | output | 1 | Lower bus output enable |
| lo_io_i | input | 4 | Lower bus input nibble |
| hi_io_o | output | 4 | Upper bus output nibble |
| hi_oe_o | output | 1 | Upper bus output enable |
| hi_io_i | input | 4 | Upper bus input nibble |

## Verification
The assertions assume that start_i only arrives while busy_o is low. They also assume that the mode, opcode, address, length and dummy inputs are valid in the start cycle, and that wr_data_i stays stable until its acknowledge. The bench applies every request only after busy_o has fallen, and it changes the write byte only after an acknowledge. Read nibbles are driven one time unit after each falling serial clock edge, so they are stable when the block samples them at the end of the high phase.

// File: rtl/dpq_pkg.sv
package dpq_pkg;

    localparam int CFG_SEP_BIT = 29;
    localparam int CFG_TWO_BIT = 30;
    localparam int HDR_SLOTS   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_END
    } dpq_state_e;

    function automatic logic par_enabled(input logic [31:0] cfg);
        return cfg[CFG_SEP_BIT] & cfg[CFG_TWO_BIT];
    endfunction

endpackage

// File: rtl/dpq_seq.sv
module dpq_seq
    import dpq_pkg::*;
#(
    parameter int LW = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          par_i,
    input  logic          wr_i,
    input  logic [7:0]    op_i,
    input  logic [23:0]   dev_addr_i,
    input  logic          odd_addr_i,
    input  logic [LW-1:0] len_i,
    input  logic [DW-1:0] dummy_i,
    output dpq_state_e    state_o,
    output logic [3:0]    hdr_nib_o,
    output logic          slot_end_o,
    output logic          half_o,
    output logic          par_o,
    output logic          wr_o,
    output logic          cs_n_o,
    output logic          sclk_o,
    output logic          busy_o,
    output logic          err_o
);
    localparam int CW = LW + 2;

    dpq_state_e    state, nxt;
    logic          ph;
    logic [CW-1:0] cnt, last;
    logic          par_q, wr_q, err_q;
    logic [7:0]    op_q;
    logic [23:0]   addr_q;
    logic [LW-1:0] len_q;
    logic [DW-1:0] dum_q;

    always_comb begin
        case (state)
            ST_CMD:   last = CW'(1);
            ST_ADDR:  last = CW'(5);
            ST_DUMMY: last = CW'(dum_q) - CW'(1);
            ST_DATA:  last = par_q ? CW'(len_q) - CW'(1) : CW'({len_q, 1'b0}) - CW'(1);
            default:  last = '0;
        endcase
    end

    always_comb begin
        case (state)
            ST_CMD:   nxt = ST_ADDR;
            ST_ADDR:  nxt = (!wr_q && dum_q != '0) ? ST_DUMMY :
                            (len_q != '0) ? ST_DATA : ST_END;
            ST_DUMMY: nxt = (len_q != '0) ? ST_DATA : ST_END;
            default:  nxt = ST_END;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ph     <= 1'b0;
            cnt    <= '0;
            err_q  <= 1'b0;
            par_q  <= 1'b0;
            wr_q   <= 1'b0;
            op_q   <= '0;
            addr_q <= '0;
            len_q  <= '0;
            dum_q  <= '0;
        end else begin
            err_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        if (par_i && (odd_addr_i || len_i[0])) begin
                            err_q <= 1'b1;
                        end else begin
                            par_q  <= par_i;
                            wr_q   <= wr_i;
                            op_q   <= op_i;
                            addr_q <= dev_addr_i;
                            len_q  <= len_i;
                            dum_q  <= dummy_i;
                            state  <= ST_CMD;
                            ph     <= 1'b0;
                            cnt    <= '0;
                        end
                    end
                end
                ST_END: state <= ST_IDLE;
                default: begin
                    ph <= ~ph;
                    if (ph) begin
                        if (cnt == last) begin
                            cnt   <= '0;
                            state <= nxt;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        hdr_nib_o = '0;
        if (state == ST_CMD) begin
            hdr_nib_o = cnt[0] ? op_q[3:0] : op_q[7:4];
        end else if (state == ST_ADDR) begin
            case (cnt[2:0])
                3'd0:    hdr_nib_o = addr_q[23:20];
                3'd1:    hdr_nib_o = addr_q[19:16];
                3'd2:    hdr_nib_o = addr_q[15:12];
                3'd3:    hdr_nib_o = addr_q[11:8];
                3'd4:    hdr_nib_o = addr_q[7:4];
                default: hdr_nib_o = addr_q[3:0];
            endcase
        end
    end

    assign state_o    = state;
    assign cs_n_o     = !(state inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA});
    assign sclk_o     = ph;
    assign slot_end_o = ph && !cs_n_o;
    assign half_o     = cnt[0];
    assign par_o      = par_q;
    assign wr_o       = wr_q;
    assign busy_o     = state != ST_IDLE;
    assign err_o      = err_q;

    // R8: rejected request leaves the bus idle
    p_reject_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start_i && par_i && odd_addr_i) |=> (err_o && cs_n_o));
    // R2: serial clock only inside a frame
    p_sclk_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> !cs_n_o);
    // R12: no dummy phase on writes
    p_no_dummy_write_r12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DUMMY) |-> !wr_q);
    // R1: mode fixed during a frame
    p_mode_held_r1: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && $past(!cs_n_o)) |-> $stable(par_q));
endmodule

// File: rtl/dpq_lanes.sv
module dpq_lanes
    import dpq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  dpq_state_e state_i,
    input  logic [3:0] hdr_nib_i,
    input  logic       slot_end_i,
    input  logic       half_i,
    input  logic       par_i,
    input  logic       wr_i,
    input  logic [7:0] wr_data_i,
    input  logic [3:0] lo_io_i,
    input  logic [3:0] hi_io_i,
    output logic [3:0] lo_io_o,
    output logic       lo_oe_o,
    output logic [3:0] hi_io_o,
    output logic       hi_oe_o,
    output logic       wr_ack_o,
    output logic [7:0] rd_data_o,
    output logic       rd_valid_o
);
    logic [3:0] even_nib, odd_nib;
    logic [7:0] joined;
    logic [3:0] hold_q;
    logic       hdr, dat;

    for (genvar i = 0; i < 4; i++) begin : g_bit
        assign even_nib[i]     = wr_data_i[2*i];
        assign odd_nib[i]      = wr_data_i[2*i+1];
        assign joined[2*i]     = lo_io_i[i];
        assign joined[2*i+1]   = hi_io_i[i];
    end

    assign hdr = state_i inside {ST_CMD, ST_ADDR};
    assign dat = state_i == ST_DATA;

    always_comb begin
        lo_oe_o = hdr || (dat && wr_i);
        hi_oe_o = par_i && lo_oe_o;
        lo_io_o = '0;
        hi_io_o = '0;
        if (hdr) begin
            lo_io_o = hdr_nib_i;
            hi_io_o = par_i ? hdr_nib_i : 4'h0;
        end else if (dat && wr_i) begin
            if (par_i) begin
                lo_io_o = even_nib;
                hi_io_o = odd_nib;
            end else begin
                lo_io_o = half_i ? wr_data_i[3:0] : wr_data_i[7:4];
            end
        end
    end

    assign wr_ack_o = dat && wr_i && slot_end_i && (par_i || half_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
            hold_q     <= '0;
        end else begin
            rd_valid_o <= 1'b0;
            if (dat && !wr_i && slot_end_i) begin
                if (par_i) begin
                    rd_data_o  <= joined;
                    rd_valid_o <= 1'b1;
                end else if (!half_i) begin
                    hold_q <= lo_io_i;
                end else begin
                    rd_data_o  <= {hold_q, lo_io_i};
                    rd_valid_o <= 1'b1;
                end
            end
        end
    end

    // R3: header nibbles mirrored on both buses in paired mode
    p_hdr_twin_r3: assert property (@(posedge clk) disable iff (rst)
        (hdr && par_i) |-> (lo_io_o == hi_io_o && hi_oe_o));
    // R7: read bytes only in read transfers
    p_rd_dir_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> !wr_i);
    // R5: acknowledges only in write transfers
    p_ack_dir_r5: assert property (@(posedge clk) disable iff (rst)
        wr_ack_o |-> (wr_i && lo_oe_o));
    // R7: buses released while dummy clocks run
    p_dummy_release_r7: assert property (@(posedge clk) disable iff (rst)
        (state_i == ST_DUMMY) |-> (!lo_oe_o && !hi_oe_o));
endmodule

// File: rtl/dpq_flash_ctrl.sv
module dpq_flash_ctrl
    import dpq_pkg::*;
#(
    parameter int AW       = 27,
    parameter int LW       = 8,
    parameter int DW       = 4,
    parameter int DEV_PAGE = 256,
    parameter int DEV_SECT = 4096
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [31:0]    cfg_i,
    input  logic           start_i,
    input  logic           wr_i,
    input  logic [7:0]     op_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [LW-1:0]  len_i,
    input  logic [DW-1:0]  dummy_i,
    input  logic [7:0]     wr_data_i,
    output logic           wr_ack_o,
    output logic [7:0]     rd_data_o,
    output logic           rd_valid_o,
    output logic           busy_o,
    output logic           err_o,
    output logic [AW-25:0] bank_o,
    output logic [31:0]    page_o,
    output logic [31:0]    sect_o,
    output logic           sclk_o,
    output logic           lo_cs_n_o,
    output logic           hi_cs_n_o,
    output logic [3:0]     lo_io_o,
    output logic           lo_oe_o,
    input  logic [3:0]     lo_io_i,
    output logic [3:0]     hi_io_o,
    output logic           hi_oe_o,
    input  logic [3:0]     hi_io_i
);
    localparam int BW = AW - 24;

    logic        par_now, par_q, wr_q, slot_end, half, cs_n;
    logic [23:0] dev_addr;
    logic [3:0]  hdr_nib;
    dpq_state_e  state;

    assign par_now  = par_enabled(cfg_i);
    assign dev_addr = par_now ? addr_i[24:1] : addr_i[23:0];
    assign bank_o   = par_now ? BW'(addr_i[AW-1:25]) : addr_i[AW-1:24];
    assign page_o   = 32'(DEV_PAGE) << par_now;
    assign sect_o   = 32'(DEV_SECT) << par_now;

    dpq_seq #(.LW(LW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .par_i      (par_now),
        .wr_i       (wr_i),
        .op_i       (op_i),
        .dev_addr_i (dev_addr),
        .odd_addr_i (addr_i[0]),
        .len_i      (len_i),
        .dummy_i    (dummy_i),
        .state_o    (state),
        .hdr_nib_o  (hdr_nib),
        .slot_end_o (slot_end),
        .half_o     (half),
        .par_o      (par_q),
        .wr_o       (wr_q),
        .cs_n_o     (cs_n),
        .sclk_o     (sclk_o),
        .busy_o     (busy_o),
        .err_o      (err_o)
    );

    dpq_lanes u_lanes (
        .clk        (clk),
        .rst        (rst),
        .state_i    (state),
        .hdr_nib_i  (hdr_nib),
        .slot_end_i (slot_end),
        .half_i     (half),
        .par_i      (par_q),
        .wr_i       (wr_q),
        .wr_data_i  (wr_data_i),
        .lo_io_i    (lo_io_i),
        .hi_io_i    (hi_io_i),
        .lo_io_o    (lo_io_o),
        .lo_oe_o    (lo_oe_o),
        .hi_io_o    (hi_io_o),
        .hi_oe_o    (hi_oe_o),
        .wr_ack_o   (wr_ack_o),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    assign lo_cs_n_o = cs_n;
    assign hi_cs_n_o = cs_n | ~par_q;

    // R2: paired selects move together
    p_cs_pair_r2: assert property (@(posedge clk) disable iff (rst)
        par_q |-> (hi_cs_n_o == lo_cs_n_o));
    // R1: upper device untouched in single mode
    p_hi_off_single_r1: assert property (@(posedge clk) disable iff (rst)
        !par_q |-> (hi_cs_n_o && !hi_oe_o));
endmodule

// File: tb/test_dpq_flash_ctrl.sv
`timescale 1ns/1ps
module test_dpq_flash_ctrl;
    localparam int AW = 27;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [31:0]   cfg_i = '0;
    logic          start_i = 1'b0, wr_i = 1'b0;
    logic [7:0]    op_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    len_i = '0;
    logic [3:0]    dummy_i = '0;
    logic [7:0]    wr_data_i;
    logic          wr_ack_o, rd_valid_o, busy_o, err_o, sclk_o;
    logic [7:0]    rd_data_o;
    logic [2:0]    bank_o;
    logic [31:0]   page_o, sect_o;
    logic          lo_cs_n_o, hi_cs_n_o, lo_oe_o, hi_oe_o;
    logic [3:0]    lo_io_o, hi_io_o;
    logic [3:0]    lo_in = '0, hi_in = '0;

    dpq_flash_ctrl i_dpq_flash_ctrl (
        .clk(clk), .rst(rst), .cfg_i(cfg_i), .start_i(start_i), .wr_i(wr_i),
        .op_i(op_i), .addr_i(addr_i), .len_i(len_i), .dummy_i(dummy_i),
        .wr_data_i(wr_data_i), .wr_ack_o(wr_ack_o), .rd_data_o(rd_data_o),
        .rd_valid_o(rd_valid_o), .busy_o(busy_o), .err_o(err_o), .bank_o(bank_o),
        .page_o(page_o), .sect_o(sect_o), .sclk_o(sclk_o), .lo_cs_n_o(lo_cs_n_o),
        .hi_cs_n_o(hi_cs_n_o), .lo_io_o(lo_io_o), .lo_oe_o(lo_oe_o), .lo_io_i(lo_in),
        .hi_io_o(hi_io_o), .hi_oe_o(hi_oe_o), .hi_io_i(hi_in)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    function automatic logic [7:0] wval(input int i);
        return 8'(8'h3C + i * 29);
    endfunction
    function automatic logic [7:0] fval(input int i);
        return 8'(8'hA5 ^ (i * 37));
    endfunction
    function automatic logic [3:0] ev(input logic [7:0] b);
        return {b[6], b[4], b[2], b[0]};
    endfunction
    function automatic logic [3:0] od(input logic [7:0] b);
        return {b[7], b[5], b[3], b[1]};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // responder: capture every rising serial clock edge
    logic [7:0] nsl = '0;
    logic [3:0] cap_lo [0:255];
    logic [3:0] cap_hi [0:255];
    logic       cap_loe [0:255];
    logic       cap_hoe [0:255];
    always @(posedge sclk_o) begin
        cap_lo[nsl]  <= lo_io_o;
        cap_hi[nsl]  <= hi_io_o;
        cap_loe[nsl] <= lo_oe_o;
        cap_hoe[nsl] <= hi_oe_o;
        nsl          <= nsl + 8'd1;
    end

    bit   cur_par = 1'b0;
    int   cur_dum = 0;
    logic [7:0] sbase = '0;
    always @(negedge sclk_o) begin
        #1;
        begin
            int idx, d;
            logic [7:0] b;
            idx = int'(8'(nsl - sbase));
            d = idx - 8 - cur_dum;
            if (d >= 0) begin
                if (cur_par) begin
                    b = fval(d);
                    lo_in = ev(b);
                    hi_in = od(b);
                end else begin
                    b = fval(d / 2);
                    lo_in = (d % 2 == 0) ? b[7:4] : b[3:0];
                    hi_in = 4'h0;
                end
            end
        end
    end

    // host-side streams and select monitors
    int widx = 0, rcnt = 0, lo_low = 0, hi_low = 0, cs_mis = 0;
    logic [7:0] rbuf [0:255];
    assign wr_data_i = wval(widx);
    always @(negedge clk) begin
        if (wr_ack_o) widx <= widx + 1;
        if (rd_valid_o) begin
            rbuf[8'(rcnt)] <= rd_data_o;
            rcnt <= rcnt + 1;
        end
        if (!lo_cs_n_o) lo_low <= lo_low + 1;
        if (!hi_cs_n_o) hi_low <= hi_low + 1;
        if (lo_cs_n_o != hi_cs_n_o) cs_mis <= cs_mis + 1;
    end

    // {mode[1:0], wr, dummy[3:0], len[7:0], addr[26:0]}; mode bit1=cfg30, bit0=cfg29
    localparam logic [41:0] VEC [0:6] = '{
        {2'd3, 1'b1, 4'd0, 8'd4, 27'h0000124},
        {2'd3, 1'b0, 4'd3, 8'd6, 27'h1000008},
        {2'd1, 1'b1, 4'd0, 8'd3, 27'h0000013},
        {2'd2, 1'b0, 4'd2, 8'd2, 27'h2345677},
        {2'd3, 1'b0, 4'd0, 8'd2, 27'h3FFFFFE},
        {2'd0, 1'b0, 4'd5, 8'd3, 27'h7ABCDE1},
        {2'd3, 1'b1, 4'd0, 8'd0, 27'h0000200}
    };

    task automatic run(input logic [41:0] v);
        logic [1:0]  mode;
        logic        wr;
        logic [3:0]  dum;
        logic [7:0]  len;
        logic [26:0] addr;
        logic [23:0] dev;
        logic [7:0]  op;
        bit par, ok_hdr, ok_twin, ok_dat, ok_oe;
        int wb, rb, l0, h0, m0, slots, nd;
        {mode, wr, dum, len, addr} = v;
        par = (mode == 2'd3);
        op  = 8'h6B ^ addr[7:0];
        @(negedge clk);
        sbase = nsl; wb = widx; rb = rcnt; l0 = lo_low; h0 = hi_low; m0 = cs_mis;
        cur_par = par; cur_dum = wr ? 0 : int'(dum);
        cfg_i = {1'b0, mode[1], mode[0], 29'h0};
        wr_i = wr; op_i = op; addr_i = addr; len_i = len; dummy_i = dum;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int g = 0; g < 3000 && busy_o; g++) @(negedge clk);
        @(negedge clk);
        nd = par ? int'(len) : 2 * int'(len);
        slots = 8 + (wr ? 0 : int'(dum)) + nd;
        chk(int'(8'(nsl - sbase)) == slots, "R12 serial clock count", 8'(nsl - sbase), slots);
        dev = par ? addr[24:1] : addr[23:0];
        ok_hdr = 1; ok_twin = 1; ok_oe = 1;
        for (int i = 0; i < 8; i++) begin
            logic [3:0] e;
            e = (i < 2) ? ((i == 0) ? op[7:4] : op[3:0]) : 4'(dev >> (4 * (7 - i)));
            if (cap_lo[8'(sbase + i)] !== e || !cap_loe[8'(sbase + i)]) ok_hdr = 0;
            if (par && (cap_hi[8'(sbase + i)] !== e || !cap_hoe[8'(sbase + i)])) ok_twin = 0;
            if (!par && cap_hoe[8'(sbase + i)]) ok_twin = 0;
        end
        chk(ok_hdr, "R3/R4 header nibbles on lower bus", 0, dev);
        chk(ok_twin, par ? "R3 upper header mirror" : "R1 upper bus quiet", 0, 1);
        if (!wr) begin
            for (int i = 0; i < int'(dum); i++)
                if (cap_loe[8'(sbase + 8 + i)] || cap_hoe[8'(sbase + 8 + i)]) ok_oe = 0;
            chk(ok_oe, "R7 buses released in dummy", 0, 1);
            chk(rcnt - rb == int'(len), "R7 read byte count", rcnt - rb, len);
            for (int k = 0; k < int'(len); k++)
                chk(rbuf[8'(rb + k)] == fval(k), par ? "R7 paired read byte" : "R7 single read byte",
                    rbuf[8'(rb + k)], fval(k));
        end else begin
            ok_dat = 1;
            for (int k = 0; k < int'(len); k++) begin
                logic [7:0] b;
                b = wval(wb + k);
                if (par) begin
                    if (cap_lo[8'(sbase + 8 + k)] !== ev(b) || cap_hi[8'(sbase + 8 + k)] !== od(b)) ok_dat = 0;
                end else begin
                    if (cap_lo[8'(sbase + 8 + 2*k)] !== b[7:4] || cap_lo[8'(sbase + 9 + 2*k)] !== b[3:0]) ok_dat = 0;
                end
            end
            chk(ok_dat, par ? "R5 split write nibbles" : "R6 single write nibbles", 0, 1);
            chk(widx - wb == int'(len), "R5 write acknowledges", widx - wb, len);
        end
        if (par) begin
            chk(cs_mis == m0 && (hi_low - h0) == (lo_low - l0), "R2 selects paired",
                cs_mis - m0, 0);
        end else begin
            chk(hi_low == h0 && lo_low > l0, "R1 only lower select", hi_low - h0, 0);
        end
    endtask

    task automatic reject(input logic [26:0] addr, input logic [7:0] len, input string tag);
        int l0;
        @(negedge clk);
        l0 = lo_low;
        cfg_i = 32'h6000_0000; wr_i = 1'b0; addr_i = addr; len_i = len; dummy_i = 4'd0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o === 1'b1, tag, err_o, 1);
        @(negedge clk);
        chk(err_o === 1'b0 && !busy_o && lo_low == l0, "R8 no transfer after reject", lo_low - l0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(lo_cs_n_o && hi_cs_n_o, "R11 selects high in reset", {lo_cs_n_o, hi_cs_n_o}, 3);
        rst = 1'b0;
        @(negedge clk);
        chk(!sclk_o && !lo_oe_o && !hi_oe_o && !busy_o, "R11 idle outputs",
            {sclk_o, lo_oe_o, hi_oe_o, busy_o}, 0);
        for (int t = 0; t < 7; t++) run(VEC[t]);
        reject(27'h0000101, 8'd2, "R8 odd address rejected");
        reject(27'h0000100, 8'd3, "R8 odd length rejected");
        // R9, R10: geometry and bank reporting
        addr_i = 27'h5000000;
        cfg_i = 32'h6000_0000;
        @(negedge clk);
        chk(bank_o == 3'd2, "R9 paired bank", bank_o, 2);
        chk(page_o == 512 && sect_o == 8192, "R10 paired sizes", page_o, 512);
        cfg_i = 32'h4000_0000;
        @(negedge clk);
        chk(bank_o == 3'd5, "R9 single bank", bank_o, 5);
        chk(page_o == 256 && sect_o == 4096, "R10 single sizes", page_o, 256);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule